// File: doc/BRIEF.md
# Grayscale PWM Channel Generator

This block turns three 12-bit brightness words into three single-bit pulse-width outputs. One shared 12-bit grayscale counter runs over a frame of 4096 counts. Each channel output is high from count 000h until the count reaches that channel's stored value. A value of N therefore gives a pulse that is N count periods long. The count advances on a count tick. A select pin chooses where the tick comes from: every second system clock (the internal oscillator divided by two), or each rising edge of an external shift clock. The external clock is sampled in the system clock domain.

New brightness words arrive as one beat on a valid/ready input. An accepted beat is the latch pulse. Words pass through a first and a second storage stage, and the comparators read only the second stage. When timing reset is enabled, a beat loads both stages at once. It also presets the counter 16 counts below the wrap point, so each frame is preceded by a 16-count lead-in with all outputs low. When timing reset is disabled, the second stage takes the first stage's contents only at a frame start, so a running frame is never disturbed. A repeat pin chooses between a single frame per beat and an endless run of frames.

The input never applies back-pressure. `in_ready` is low only during reset and for the first cycle after it, and is high from then on. A beat is taken in any cycle where `in_valid` and `in_ready` are both high.

Top module: `gs_pwm_top`

## Requirements
- R1: With `src_ext`=1 the counter advances once per rising edge of `ext_sclk`. With `src_ext`=0 it advances once every two `clk` cycles. Either way a channel value of N gives a high time of N tick periods.
- R2: With `dtr_en`=1 an accepted beat presets the counter to FF0h and loads both storage stages from `in_gs` in the same cycle. Channel k uses bits [12k+11:12k].
- R3: All outputs stay low during the lead-in, while the counter runs from FF0h to FFFh before the first frame.
- R4: Within a frame, a channel is high from count 000h while the count is below its stored value. 000h never turns it on, and FFFh holds it high for 4095 tick periods.
- R5: With `dtr_en`=0 a beat loads only the first stage, and the second stage copies it when the counter wraps to 000h. A beat taken mid-frame does not change that frame. A beat taken while the generator is idle starts a lead-in.
- R6: With `rpt_en`=0 the generator runs one frame after a beat, and then keeps all outputs low until the next beat.
- R7: With `rpt_en`=1 frames repeat back to back after every wrap, and each frame drives the same pulse widths.
- R8: While `rst_n` is low, the counter, both stages and all outputs are cleared and `in_ready` is low. After reset the outputs stay low until a beat is taken.
- R9: `in_ready` goes high in the first cycle after reset and stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ext | input | 1 | Count source: 1 = external shift clock, 0 = clk divided by two |
| dtr_en | input | 1 | Timing reset: a beat presets the counter and loads both stages |
| rpt_en | input | 1 | Repeat frames continuously |
| ext_sclk | input | 1 | External shift clock, sampled on clk |
| in_valid | input | 1 | Brightness beat valid (latch pulse) |
| in_ready | output | 1 | Beat accepted when high with in_valid |
| in_gs | input | 36 | Three 12-bit brightness words, channel 0 in the low bits |
| pwm_out | output | 3 | One PWM output per channel |

## Verification
The bench measures pulse widths in clock cycles across whole frames. It uses the values 000h, 001h, 002h, 3FFh, 400h, 401h, 7FFh, 800h, FFEh and FFFh. A counter that was off by one, or a comparison written as at-or-below, would show up as a width one tick period away from the expected value. It checks that the outputs stay quiet through the lead-in, and that no second pulse appears after a single-frame run. A generator that compared during the lead-in, or kept running without repeat enabled, would fail these checks. With timing reset off, it sends a second beat in the middle of a long pulse. A design that loaded the second stage at once would cut that pulse short. Repeated frames and the external clock source are each measured against their expected tick periods.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} tick_src_e;

  function automatic int unsigned lead_start(input int unsigned width, input int unsigned lead);
    return (1 << width) - lead;
  endfunction
endpackage

// File: rtl/gs_tick_gen.sv
module gs_tick_gen
  import gs_pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_ext,
  input  logic ext_sclk,
  output logic tick
);
  logic half_q;
  logic sclk_q;
  tick_src_e src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      half_q <= ~half_q;
      sclk_q <= ext_sclk;
    end
  end

  assign src  = tick_src_e'(src_ext);
  assign tick = (src == SRC_EXT) ? (ext_sclk & ~sclk_q) : half_q;
endmodule

// File: rtl/gs_frame_ctr.sv
module gs_frame_ctr
  import gs_pwm_pkg::*;
#(
  parameter int GSW  = 12,
  parameter int LEAD = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           take,
  input  logic           dtr_en,
  input  logic           rpt_en,
  output logic [GSW-1:0] cnt,
  output logic           running,
  output logic           in_frame,
  output logic           frame_start
);
  localparam logic [GSW-1:0] PRESET = GSW'(lead_start(GSW, LEAD));
  localparam logic [GSW-1:0] TOP    = {GSW{1'b1}};

  logic restart;
  logic at_top;

  assign restart     = take && (dtr_en || !running);
  assign at_top      = running && tick && (cnt == TOP);
  assign frame_start = !restart && at_top && (!in_frame || rpt_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      running  <= 1'b0;
      in_frame <= 1'b0;
    end else if (restart) begin
      cnt      <= PRESET;
      running  <= 1'b1;
      in_frame <= 1'b0;
    end else if (frame_start) begin
      cnt      <= '0;
      in_frame <= 1'b1;
    end else if (at_top) begin
      cnt      <= '0;
      running  <= 1'b0;
      in_frame <= 1'b0;
    end else if (running && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gs_latch_pair.sv
module gs_latch_pair #(
  parameter int NCH = 3,
  parameter int GSW = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    dtr_en,
  input  logic                    frame_start,
  input  logic [NCH-1:0][GSW-1:0] din,
  output logic [NCH-1:0][GSW-1:0] stage2
);
  logic [NCH-1:0][GSW-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      if (take) stage1 <= din;
      if (take && dtr_en) stage2 <= din;
      else if (frame_start && !dtr_en) stage2 <= stage1;
    end
  end
endmodule

// File: rtl/gs_chan_cmp.sv
module gs_chan_cmp #(
  parameter int GSW = 12
) (
  input  logic           in_frame,
  input  logic [GSW-1:0] cnt,
  input  logic [GSW-1:0] level,
  output logic           on
);
  assign on = in_frame && (cnt < level);
endmodule

// File: rtl/gs_pwm_top.sv
module gs_pwm_top #(
  parameter int NCH  = 3,
  parameter int GSW  = 12,
  parameter int LEAD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_ext,
  input  logic             dtr_en,
  input  logic             rpt_en,
  input  logic             ext_sclk,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NCH*GSW-1:0] in_gs,
  output logic [NCH-1:0]   pwm_out
);
  logic                    tick;
  logic                    take;
  logic [GSW-1:0]          cnt;
  logic                    running;
  logic                    in_frame;
  logic                    frame_start;
  logic [NCH-1:0][GSW-1:0] level;
  logic                    rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign take     = in_valid && rdy_q;

  gs_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .ext_sclk(ext_sclk), .tick(tick)
  );

  gs_frame_ctr #(.GSW(GSW), .LEAD(LEAD)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(take), .dtr_en(dtr_en),
    .rpt_en(rpt_en), .cnt(cnt), .running(running), .in_frame(in_frame),
    .frame_start(frame_start)
  );

  gs_latch_pair #(.NCH(NCH), .GSW(GSW)) u_lat (
    .clk(clk), .rst_n(rst_n), .take(take), .dtr_en(dtr_en),
    .frame_start(frame_start), .din(in_gs), .stage2(level)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    gs_chan_cmp #(.GSW(GSW)) u_cmp (
      .in_frame(in_frame), .cnt(cnt), .level(level[k]), .on(pwm_out[k])
    );
  end
endmodule

// File: rtl/gs_pwm_chk.sv
module gs_pwm_chk #(
  parameter int NCH  = 3,
  parameter int GSW  = 12,
  parameter int LEAD = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    dtr_en,
  input logic                    rpt_en,
  input logic                    take,
  input logic                    tick,
  input logic [GSW-1:0]          cnt,
  input logic                    running,
  input logic                    in_frame,
  input logic [NCH-1:0][GSW-1:0] level,
  input logic [NCH-1:0]          pwm_out
);
  localparam logic [GSW-1:0] PRESET = GSW'((1 << GSW) - LEAD);
  localparam logic [GSW-1:0] TOP    = {GSW{1'b1}};

  // R2: a beat with timing reset enabled starts a lead-in at the preset count
  a_r2_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dtr_en) |=> (cnt == PRESET && running && !in_frame));

  // R3: outputs are quiet while running outside a frame
  a_r3_lead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !in_frame) |-> (pwm_out == '0));

  // R4: a rising output only happens at count zero of a frame
  for (genvar k = 0; k < NCH; k++) begin : g_rise
    a_r4_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[k]) |-> (in_frame && cnt == '0));
  end

  // R5: without timing reset the second stage holds except at a wrap
  a_r5_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtr_en && !(running && tick && cnt == TOP)) |=> $stable(level));

  // R6: single-frame mode stops at the end of the frame
  a_r6_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && tick && cnt == TOP && !rpt_en && !take) |=> !running);

  // R1: the counter steps by one per tick
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !take && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

  // R8: reset clears the outputs
  a_r8_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (pwm_out == '0 && !running));
endmodule

bind gs_pwm_top gs_pwm_chk #(.NCH(NCH), .GSW(GSW), .LEAD(LEAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .dtr_en(dtr_en), .rpt_en(rpt_en), .take(take),
  .tick(tick), .cnt(cnt), .running(running), .in_frame(in_frame),
  .level(level), .pwm_out(pwm_out)
);

// File: tb/gs_pwm_top_tb.sv
module gs_pwm_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int GSW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_ext = 1'b0;
  logic dtr_en = 1'b1;
  logic rpt_en = 1'b0;
  logic ext_sclk = 1'b0;
  logic ext_on = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NCH*GSW-1:0] in_gs = '0;
  logic [NCH-1:0] pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  int hi [NCH];
  int ediv = 0;

  // {ch0, ch1, ch2, dtr_en}
  localparam logic [36:0] VEC [5] = '{
    {12'h000, 12'h001, 12'hFFF, 1'b1},
    {12'h3FF, 12'h400, 12'h401, 1'b1},
    {12'hFFE, 12'h002, 12'h000, 1'b0},
    {12'h123, 12'hABC, 12'h7FF, 1'b1},
    {12'h001, 12'h000, 12'h800, 1'b0}
  };

  gs_pwm_top u_dut (
    .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .dtr_en(dtr_en),
    .rpt_en(rpt_en), .ext_sclk(ext_sclk), .in_valid(in_valid),
    .in_ready(in_ready), .in_gs(in_gs), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (ext_on) begin
      if (ediv == 3) begin
        ext_sclk <= ~ext_sclk;
        ediv <= 0;
      end else begin
        ediv <= ediv + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ext_on = 1'b0;
    ext_sclk = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic beat(input logic [11:0] a, input logic [11:0] b, input logic [11:0] c);
    in_gs = {c, b, a};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic window(input int w);
    for (int k = 0; k < NCH; k++) hi[k] = 0;
    for (int i = 0; i < w; i++) begin
      for (int k = 0; k < NCH; k++) if (pwm_out[k]) hi[k]++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 outputs in reset", int'(pwm_out), 0);
    check("R8 ready low in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 ready after reset", int'(in_ready), 1);
    window(9000);
    check("R8 idle until beat", hi[0] + hi[1] + hi[2], 0);

    // R2 R4 R5 R6: table of vectors, internal source, single frame
    foreach (VEC[v]) begin
      dtr_en = VEC[v][0];
      beat(VEC[v][36:25], VEC[v][24:13], VEC[v][12:1]);
      window(8400);
      check($sformatf("R4 vec%0d ch0", v), hi[0], 2 * int'(VEC[v][36:25]));
      check($sformatf("R4 vec%0d ch1", v), hi[1], 2 * int'(VEC[v][24:13]));
      check($sformatf("R2 vec%0d ch2", v), hi[2], 2 * int'(VEC[v][12:1]));
    end
    window(8400);
    check("R6 no second frame", hi[0] + hi[1] + hi[2], 0);

    // R3: lead-in quiet with full-scale values
    dtr_en = 1'b1;
    beat(12'hFFF, 12'hFFF, 12'hFFF);
    window(28);
    check("R3 lead-in quiet", hi[0] + hi[1] + hi[2], 0);
    window(8400);

    // R7: repeated frames
    do_reset();
    rpt_en = 1'b1;
    dtr_en = 1'b1;
    beat(12'h00A, 12'h014, 12'h000);
    window(16400);
    check("R7 two frames ch0", hi[0], 40);
    check("R7 two frames ch1", hi[1], 80);
    check("R7 two frames ch2", hi[2], 0);

    // R5: mid-frame beat without timing reset leaves the frame alone
    do_reset();
    rpt_en = 1'b1;
    dtr_en = 1'b0;
    beat(12'h800, 12'h004, 12'h000);
    for (int k = 0; k < NCH; k++) hi[k] = 0;
    for (int i = 0; i < 8200; i++) begin
      for (int k = 0; k < NCH; k++) if (pwm_out[k]) hi[k]++;
      if (i == 1100) begin
        in_gs = {12'h000, 12'h100, 12'h010};
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    check("R5 frame1 ch0", hi[0], 4096);
    check("R5 frame1 ch1", hi[1], 8);
    check("R5 frame1 ch2", hi[2], 0);
    window(8192);
    check("R5 frame2 ch0", hi[0], 32);
    check("R5 frame2 ch1", hi[1], 512);
    check("R5 frame2 ch2", hi[2], 0);

    // R1: external shift clock, period 8 clk cycles
    do_reset();
    rpt_en = 1'b0;
    dtr_en = 1'b1;
    src_ext = 1'b1;
    ext_on = 1'b1;
    beat(12'h005, 12'h000, 12'h001);
    window(33000);
    check("R1 ext ch0", hi[0], 40);
    check("R1 ext ch1", hi[1], 0);
    check("R1 ext ch2", hi[2], 8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule